// File: doc/BRIEF.md
# Serial-Access SRAM Slave

This block models a byte-wide static memory reached over a four-wire SPI link with chip select, serial clock, serial in and serial out, plus a pause pin. The host first shifts in an 8-bit command, MSB first. Read and write commands are followed by a 16-bit address, and the data bytes come after that. Two other commands read and write a small mode register. That register chooses how the address pointer moves after each byte: it can stay on a single byte, cycle within a 32-byte page, or run through the whole array. It also decides whether the pause pin is honoured.

The serial pins are asynchronous to the block's clock. They pass through a synchronizer chain, and the serial clock edges are found by comparing successive samples. For this reason the system clock must run several times faster than the serial clock. The array holds 2**ADDR_W bytes. ADDR_W = 13 gives the full 8K x 8 device. The default of 11 keeps the elaborated memory small.

A pause is requested by driving the pause pin low. It takes effect at once if the serial clock is low. If the serial clock is high, it takes effect after the next falling edge. While paused, the serial clock and data are ignored and the output is released. The transfer then continues at the same bit position.

Top module: `spi_sram_slave`

## Requirements
- R1: Command bytes are 0x03 (read), 0x02 (write), 0x05 (read mode register) and 0x01 (write mode register), all shifted MSB first. Any other command is ignored until chip select rises, with no output drive and no change of state.
- R2: Read and write commands take a 16-bit address, MSB first. Only the low ADDR_W bits select the byte, and the upper bits are ignored.
- R3: SI is captured on rising serial clock edges. SO changes after falling edges and is launched on the falling edge that follows the last address bit. so_oe is low whenever chip select is high or no read is in progress.
- R4: Raising chip select aborts any transfer, including a partial byte, which is not stored. The next falling chip select starts a new command, whose first rising edge carries command bit 7.
- R5: Word mode (register bits [7:6] = 00, or the reserved value 11): a read returns the addressed byte first, and a write stores only the first data byte. Further data bits are ignored.
- R6: Page mode (bits [7:6] = 10): the pointer advances after each byte and wraps from offset 31 to offset 0 of the same 32-byte page.
- R7: Burst mode (bits [7:6] = 01): the pointer advances through the whole array and wraps from the last address to 0.
- R8: The mode register resets to word mode with pause enabled. A write keeps bits [7:6] and bit 0 and discards bits [5:1]. A read returns {mode, 0000, 1, bit0}, so the reset value reads 0x02.
- R9: With bit 0 = 0, pulling hold_n low while the serial clock is low pauses the transfer at once. SO is released and serial clock edges are ignored. Raising hold_n while the serial clock is low resumes at the same bit.
- R10: If hold_n falls while the serial clock is high, the next falling edge is still processed and the pause starts after it. so_oe drops as soon as hold_n is low.
- R11: With bit 0 = 1, hold_n has no effect on transfers or on so_oe.
- R12: standby is high exactly while the synchronized chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than sck |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the host |
| si | input | 1 | Serial data from the host |
| hold_n | input | 1 | Pause request, active low |
| so | output | 1 | Serial data to the host |
| so_oe | output | 1 | Output enable for so; low means high impedance |
| standby | output | 1 | High while the device is deselected |

## Verification
The address pointer is driven through all three modes:
- A burst write fills the whole small array and continues past its end, starting at an address with nonzero ignored upper bits. A burst read then crosses the top of the array. This separates a full-array wrap from a page wrap and from a truncated address.
- Page writes and page reads cross a page boundary, which shows any carry leaking into the page number.
- Word-mode reads sample a stride across the array. A two-byte word write shows whether the second byte leaks into the next address.

The pause pin is tested in three ways: low during a low clock phase, low during a high clock phase, and low while disabled. In each case the resumed byte must come back intact. Unknown commands and transfers aborted mid-byte must leave both the array and the mode register unchanged.

// File: rtl/spi_sram_slave.sv
module spi_sram_slave #(
  parameter int ADDR_W  = 11,
  parameter int PAGE_W  = 5,
  parameter int SYNC_ST = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  input  logic hold_n,
  output logic so,
  output logic so_oe,
  output logic standby
);
  localparam int DEPTH = 1 << ADDR_W;

  typedef enum logic [2:0] {ST_CMD, ST_ADDR, ST_RD, ST_WR, ST_SRRD, ST_SRWR, ST_IDLE} st_t;

  logic [3:0] syn [SYNC_ST];
  logic cs_s, sck_s, si_s, hold_s;
  assign {cs_s, sck_s, si_s, hold_s} = syn[SYNC_ST-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < SYNC_ST; i++) syn[i] <= 4'b1001;
    end else begin
      syn[0] <= {cs_n, sck, si, hold_n};
      for (int i = 1; i < SYNC_ST; i++) syn[i] <= syn[i-1];
    end

  st_t st;
  logic is_rd, sck_q, paused, oe_r, so_r, hold_dis;
  logic [3:0] bitcnt;
  logic [15:0] sh;
  logic [1:0] mode;
  logic [ADDR_W-1:0] ptr;
  logic [7:0] mem [DEPTH];

  wire act    = ~cs_s & ~paused;
  wire rise   = act & sck_s & ~sck_q;
  wire fall   = act & ~sck_s & sck_q;
  wire hold_en = ~hold_dis;
  wire [15:0] addr_full = {sh[14:0], si_s};
  wire [7:0] in_byte = addr_full[7:0];
  wire is_page  = (mode == 2'b10);
  wire is_burst = (mode == 2'b01);
  wire [ADDR_W-1:0] next_ptr = is_burst ? ptr + 1'b1
                             : {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + 1'b1};
  wire [7:0] rd_byte = mem[ptr];
  wire [7:0] sr_view = {mode, 4'b0000, 1'b1, hold_dis};
  logic unused_hi;
  assign unused_hi = ^addr_full[15:ADDR_W];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= ST_CMD; is_rd <= 1'b0; sck_q <= 1'b0; paused <= 1'b0;
      oe_r <= 1'b0; so_r <= 1'b0; hold_dis <= 1'b0; mode <= 2'b00;
      bitcnt <= '0; sh <= '0; ptr <= '0;
    end else begin
      sck_q <= sck_s;
      if (cs_s) begin
        st <= ST_CMD; bitcnt <= '0; paused <= 1'b0; oe_r <= 1'b0;
      end else begin
        if (!hold_en) paused <= 1'b0;
        else if (!paused && !hold_s && !sck_s) paused <= 1'b1;
        else if (paused && hold_s && !sck_s) paused <= 1'b0;

        if (rise) begin
          sh <= addr_full;
          bitcnt <= bitcnt + 1'b1;
          unique case (st)
            ST_CMD: if (bitcnt == 4'd7) begin
              bitcnt <= '0;
              case (in_byte)
                8'h03: begin st <= ST_ADDR; is_rd <= 1'b1; end
                8'h02: begin st <= ST_ADDR; is_rd <= 1'b0; end
                8'h05: st <= ST_SRRD;
                8'h01: st <= ST_SRWR;
                default: st <= ST_IDLE;
              endcase
            end
            ST_ADDR: if (bitcnt == 4'd15) begin
              bitcnt <= '0;
              ptr <= addr_full[ADDR_W-1:0];
              st <= is_rd ? ST_RD : ST_WR;
            end
            ST_WR: if (bitcnt == 4'd7) begin
              bitcnt <= '0;
              if (is_page || is_burst) ptr <= next_ptr;
              else st <= ST_IDLE;
            end
            ST_SRWR: if (bitcnt == 4'd7) begin
              bitcnt <= '0;
              mode <= in_byte[7:6];
              hold_dis <= in_byte[0];
              st <= ST_IDLE;
            end
            default: bitcnt <= bitcnt;
          endcase
        end

        if (fall && (st == ST_RD || st == ST_SRRD)) begin
          oe_r <= 1'b1;
          so_r <= (st == ST_RD) ? rd_byte[~bitcnt[2:0]] : sr_view[~bitcnt[2:0]];
          bitcnt <= (bitcnt == 4'd7) ? 4'd0 : bitcnt + 1'b1;
          if (st == ST_RD && bitcnt == 4'd7 && (is_page || is_burst)) ptr <= next_ptr;
        end
      end
    end

  always_ff @(posedge clk)
    if (rise && st == ST_WR && bitcnt == 4'd7) mem[ptr] <= in_byte;

  assign so      = so_r;
  assign so_oe   = oe_r & ~cs_s & ~paused & ~(hold_en & ~hold_s);
  assign standby = cs_s;

  p_cs_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> (st == ST_CMD && bitcnt == 4'd0 && !paused && !oe_r));

  p_oe_only_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    so_oe |-> (st == ST_RD || st == ST_SRRD));

  p_page_stays_r6: assert property (@(posedge clk) disable iff (!rst_n || cs_s)
    (is_page && (st == ST_RD || st == ST_WR) && $past(st) == st)
      |-> ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W]));

  p_burst_step_r7: assert property (@(posedge clk) disable iff (!rst_n || cs_s)
    (is_burst && (st == ST_RD || st == ST_WR) && $past(st) == st && ptr != $past(ptr))
      |-> ptr == $past(ptr) + 1'b1);

  p_pause_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n || cs_s)
    paused |=> ($stable(ptr) && $stable(bitcnt) && $stable(so_r)));

  p_nohold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    hold_dis |-> !paused);
endmodule

// File: tb/spi_sram_slave_tb_top.sv
`timescale 1ns/1ps
module spi_sram_slave_tb_top;
  localparam int AW = 8;
  localparam int H  = 5;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1;
  logic so, so_oe, standby;
  int total = 0, bad = 0;
  logic [7:0] mdl [256];

  always #4 clk = ~clk;

  spi_sram_slave #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
    .so(so), .so_oe(so_oe), .standby(standby));

  task automatic chk(input int act, input int exp, input string tag);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bitx(input logic b, output logic r);
    si = b; w(H); r = so; sck = 1'b1; w(H); sck = 1'b0;
  endtask

  task automatic xbyte(input logic [7:0] t, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) bitx(t[i], r[i]);
  endtask

  task automatic start();
    cs_n = 1'b0; w(H);
  endtask

  task automatic stop();
    w(H); cs_n = 1'b1; w(2*H);
  endtask

  task automatic cmd_addr(input logic [7:0] c, input logic [15:0] a);
    logic [7:0] d;
    xbyte(c, d); xbyte(a[15:8], d); xbyte(a[7:0], d);
  endtask

  task automatic setsr(input logic [7:0] v);
    logic [7:0] d;
    start(); xbyte(8'h01, d); xbyte(v, d); stop();
  endtask

  task automatic rdsr(output logic [7:0] v);
    logic [7:0] d;
    start(); xbyte(8'h05, d); xbyte(8'h00, v); stop();
  endtask

  function automatic logic [7:0] pat(input int k);
    return 8'((k * 37 + 11) ^ (k >> 3));
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d, r;
    logic b;
    w(3); rst_n = 1'b1; w(4);
    chk(so_oe, 0, "R3 reset so_oe");
    chk(standby, 1, "R12 reset standby");
    cs_n = 1'b0; w(H);
    chk(standby, 0, "R12 selected standby");
    cs_n = 1'b1; w(2*H);

    rdsr(r); chk(r, 8'h02, "R8 default register");
    setsr(8'h7F); rdsr(r); chk(r, 8'h43, "R8 reserved bits dropped");
    setsr(8'h40); rdsr(r); chk(r, 8'h42, "R8 burst hold enabled");

    // R7 / R2: burst write past array end, upper address bits set
    start(); cmd_addr(8'h02, 16'hE010);
    for (int k = 0; k < 272; k++) begin
      xbyte(pat(k), d);
      mdl[(16 + k) & 255] = pat(k);
      if (k == 3) chk(so_oe, 0, "R3 so_oe during write");
    end
    stop();
    start(); cmd_addr(8'h03, 16'h00F8);
    for (int i = 0; i < 264; i++) begin
      xbyte(8'h00, r);
      chk(r, mdl[(248 + i) & 255], "R7 burst read wrap");
    end
    stop();

    // R6: page mode
    setsr(8'h80); rdsr(r); chk(r, 8'h82, "R8 page mode readback");
    start(); cmd_addr(8'h02, 16'h005C);
    for (int i = 0; i < 40; i++) begin
      xbyte(8'(8'hA0 + i), d);
      mdl[8'h40 | ((28 + i) & 31)] = 8'(8'hA0 + i);
    end
    stop();
    start(); cmd_addr(8'h03, 16'h005C);
    for (int i = 0; i < 40; i++) begin
      xbyte(8'h00, r);
      chk(r, mdl[8'h40 | ((28 + i) & 31)], "R6 page read wrap");
    end
    stop();
    start(); cmd_addr(8'h03, 16'h007E);
    for (int i = 0; i < 34; i++) begin
      xbyte(8'h00, r);
      chk(r, mdl[8'h60 | ((30 + i) & 31)], "R6 page read upper page");
    end
    stop();

    // R5: word mode
    setsr(8'h00);
    start(); cmd_addr(8'h02, 16'h0033); xbyte(8'hC3, d); xbyte(8'h3C, d); stop();
    mdl[8'h33] = 8'hC3;
    start(); cmd_addr(8'h03, 16'h0034); xbyte(8'h00, r); stop();
    chk(r, mdl[8'h34], "R5 word write second byte ignored");
    for (int a = 0; a < 256; a += 3) begin
      start(); cmd_addr(8'h03, 16'(a)); xbyte(8'h00, r); stop();
      chk(r, mdl[a], "R5 word read");
    end

    // R1: unknown command
    start(); xbyte(8'h07, d);
    xbyte(8'h01, d); chk(so_oe, 0, "R1 unknown command no drive");
    xbyte(8'hFF, d); stop();
    rdsr(r); chk(r, 8'h02, "R1 unknown command register untouched");

    // R4: abort mid-byte
    start(); cmd_addr(8'h02, 16'h0044);
    for (int i = 0; i < 4; i++) bitx(~mdl[8'h44][7-i], b);
    cs_n = 1'b1; w(2*H);
    start(); cmd_addr(8'h03, 16'h0044); xbyte(8'h00, r); stop();
    chk(r, mdl[8'h44], "R4 partial byte not stored");
    rdsr(r); chk(r, 8'h02, "R4 restart after abort");

    // R9 / R10: pause
    setsr(8'h40);
    start(); cmd_addr(8'h03, 16'h0020);
    for (int i = 7; i >= 4; i--) bitx(1'b0, r[i]);
    hold_n = 1'b0; w(H);
    chk(so_oe, 0, "R9 so released in pause");
    for (int i = 0; i < 3; i++) begin sck = 1'b1; w(H); sck = 1'b0; w(H); end
    hold_n = 1'b1; w(H);
    for (int i = 3; i >= 0; i--) bitx(1'b0, r[i]);
    chk(r, mdl[8'h20], "R9 resumed byte intact");
    xbyte(8'h00, r); chk(r, mdl[8'h21], "R9 next byte after pause");
    for (int i = 7; i >= 5; i--) bitx(1'b0, r[i]);
    si = 1'b0; w(H); r[4] = so; sck = 1'b1; w(H);
    hold_n = 1'b0; w(H);
    chk(so_oe, 0, "R10 so released while clock high");
    sck = 1'b0; w(H);
    for (int i = 0; i < 2; i++) begin sck = 1'b1; w(H); sck = 1'b0; w(H); end
    hold_n = 1'b1; w(H);
    for (int i = 3; i >= 0; i--) bitx(1'b0, r[i]);
    chk(r, mdl[8'h22], "R10 deferred pause byte intact");
    stop();

    // R11: pause disabled
    setsr(8'h41);
    start(); cmd_addr(8'h03, 16'h0030);
    for (int i = 7; i >= 4; i--) bitx(1'b0, r[i]);
    hold_n = 1'b0; w(H);
    chk(so_oe, 1, "R11 hold ignored so_oe");
    for (int i = 3; i >= 0; i--) bitx(1'b0, r[i]);
    chk(r, mdl[8'h30], "R11 hold ignored data");
    hold_n = 1'b1; stop();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule